// File: doc/BRIEF.md
# DAC Test Source Selector

This block sits in the transmit path of a dual-channel DAC. It picks the 64-bit word that each channel sends every clock. Each word carries four 16-bit samples. Bits 15:0 hold the oldest sample, which leaves first, and bits 63:48 hold the newest, which leaves last. A narrower converter keeps only the upper bits of each sample.

The candidate sources are:
- the streamed payload from the upstream engine
- a loopback word
- a word from an external tone generator
- a fixed pattern built from two 16-bit values
- constant zero
- three pseudo-random sequences, two of which also come in a complemented form

Each channel has its own 4-bit source code and two override bits. One override bit forces loopback and the other forces the long pseudo-random sequence. The request line to the upstream engine is held high permanently. The output word is registered, so a change of source shows up one clock later.

The block is used for link bring-up and calibration. The far end can sum or check a known bit sequence that starts from a fixed state each time it is chosen.

Top module: `dac_test_src`

## Requirements
- R1: The effective source code selects the output as follows: 0x0 tone input, 0x2 stream input, 0x3 zero, 0x8 loopback input. Codes 0xA to 0xF give zero.
- R2: Code 0x1 outputs the fixed pattern. Samples 0 and 2 (bits 15:0 and 47:32) take the low pattern value. Samples 1 and 3 take the high pattern value.
- R3: With only the loopback override set, the effective code is 0x8. With only the sequence override set, the effective code is 0x9.
- R4: With both override bits set, neither override applies and the programmed code is used.
- R5: Code 0x6 outputs a sequence from x^7+x^6+1. Each step shifts the register left and inserts new = s[6]^s[5] at bit 0. The emitted bit is the new bit. Each clock takes 64 steps. The first bit of a clock goes to bit 15 (sample 0, most significant bit) and later bits fill towards bit 0, then sample 1 and onward. The state carries across clocks.
- R6: Code 0x7 uses the same scheme with x^15+x^14+1 (new = s[14]^s[13]). Code 0x9 uses the same scheme with x^23+x^18+1 (new = s[22]^s[17]).
- R7: Code 0x4 outputs the bitwise complement of the 7-bit sequence, and code 0x5 outputs the complement of the 15-bit sequence. Each shares its generator with the normal form.
- R8: A generator reseeds to all ones on reset. It also reseeds in any cycle where the effective code differs from the previous cycle's and names one of that generator's codes. Switching between the normal and complemented form counts as a reseed. The first word after a reseed is produced from the all-ones state. Generators free-run otherwise.
- R9: The output register updates on every clock edge, with one clock of latency from the inputs to the output.
- R10: The valid line to the upstream engine reads 1 at all times, including during reset.
- R11: During reset every channel's output word is zero.
- R12: The two channels choose their sources and run their generators independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_mode | input | 2x4 | Programmed source code per channel |
| ovr_loop | input | 2 | Loopback override per channel |
| ovr_pn | input | 2 | Long-sequence override per channel |
| patt_lo | input | 2x16 | Pattern value for samples 0 and 2 |
| patt_hi | input | 2x16 | Pattern value for samples 1 and 3 |
| stream_in | input | 2x64 | Streamed payload per channel |
| loop_in | input | 2x64 | Loopback word per channel |
| tone_in | input | 2x64 | Tone generator word per channel |
| src_valid | output | 1 | Request to upstream, always 1 |
| dout | output | 2x64 | Registered output word per channel |

## Verification
A generator whose state has slipped by even one step shows up in the next output word: every one of the 64 bit positions follows from that state, so the far end sees a mismatch within one clock. A missed reseed shows in the first word after a source change, because that word must equal the fixed all-ones expansion. A mis-resolved override shows the wrong source one clock after the override bits change. The scoreboard models each generator from the polynomials and compares both channels on every clock.

// File: rtl/dac_src_pkg.sv
// Package: source codes and the override resolution shared by the selector.
// Assumes 4-bit source codes; unlisted codes are treated as zero output.
package dac_src_pkg;
    localparam logic [3:0] SEL_TONE    = 4'h0;
    localparam logic [3:0] SEL_PATTERN = 4'h1;
    localparam logic [3:0] SEL_STREAM  = 4'h2;
    localparam logic [3:0] SEL_ZERO    = 4'h3;
    localparam logic [3:0] SEL_NPN7    = 4'h4;
    localparam logic [3:0] SEL_NPN15   = 4'h5;
    localparam logic [3:0] SEL_PN7     = 4'h6;
    localparam logic [3:0] SEL_PN15    = 4'h7;
    localparam logic [3:0] SEL_LOOP    = 4'h8;
    localparam logic [3:0] SEL_PN23    = 4'h9;

    // Override resolution: exactly one override wins, both cancel out.
    function automatic logic [3:0] resolve_sel(input logic [3:0] prog,
                                               input logic lb,
                                               input logic pn);
        logic [3:0] r;
        r = prog;
        if (lb && !pn) r = SEL_LOOP;
        if (pn && !lb) r = SEL_PN23;
        return r;
    endfunction
endpackage

// File: rtl/dac_prbs_gen.sv
// Module: multi-step Fibonacci LFSR producing LANES*SAMP_W bits per clock.
// Each step shifts left and inserts s[ORDER-1]^s[TAP-1]; the emitted bit
// is the inserted bit. The first bit of a clock lands in the MSB of lane 0.
// Assumes ORDER > TAP >= 1. Reseeds to all ones on reset or on restart;
// when restart is high the word of that cycle already comes from the seed.
module dac_prbs_gen #(
    parameter int ORDER  = 7,
    parameter int TAP    = 6,
    parameter int LANES  = 4,
    parameter int SAMP_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      restart,
    output logic [LANES*SAMP_W-1:0]   word
);
    localparam int NBITS = LANES * SAMP_W;

    logic [ORDER-1:0] state;
    logic [ORDER-1:0] next_state;

    // Unroll NBITS generator steps and place each bit in oldest-first lane order.
    always_comb begin
        logic [ORDER-1:0] s;
        logic             fb;
        s    = restart ? {ORDER{1'b1}} : state;
        word = '0;
        for (int i = 0; i < NBITS; i++) begin
            fb = s[ORDER-1] ^ s[TAP-1];
            s  = {s[ORDER-2:0], fb};
            word[(i / SAMP_W) * SAMP_W + (SAMP_W - 1 - (i % SAMP_W))] = fb;
        end
        next_state = s;
    end

    // Generator state register, seeded to all ones by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= {ORDER{1'b1}};
        else        state <= next_state;
    end

    AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);  // R8

    AST_RESTART_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> state == {ORDER{1'b1}});  // R8
endmodule

// File: rtl/dac_src_chan.sv
// Module: one channel of the source selector. Resolves the overrides,
// runs the three sequence generators, and registers the chosen word.
// Assumes samples of SAMP_W bits with lane 0 in the least significant bits.
module dac_src_chan
    import dac_src_pkg::*;
#(
    parameter int SAMP_W = 16,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [3:0]                sel_mode,
    input  logic                      ovr_loop,
    input  logic                      ovr_pn,
    input  logic [SAMP_W-1:0]         patt_lo,
    input  logic [SAMP_W-1:0]         patt_hi,
    input  logic [LANES*SAMP_W-1:0]   stream_in,
    input  logic [LANES*SAMP_W-1:0]   loop_in,
    input  logic [LANES*SAMP_W-1:0]   tone_in,
    output logic [LANES*SAMP_W-1:0]   dout
);
    localparam int WORD_W = LANES * SAMP_W;
    localparam int NGEN   = 3;
    localparam int         GEN_ORDER [NGEN] = '{7, 15, 23};
    localparam int         GEN_TAP   [NGEN] = '{6, 14, 18};
    localparam logic [3:0] GEN_NORM  [NGEN] = '{SEL_PN7,  SEL_PN15,  SEL_PN23};
    localparam logic [3:0] GEN_INV   [NGEN] = '{SEL_NPN7, SEL_NPN15, SEL_PN23};

    logic [3:0]        eff_sel;
    logic [3:0]        prev_sel;
    logic [NGEN-1:0]   restart;
    logic [WORD_W-1:0] pn_word [NGEN];
    logic [WORD_W-1:0] patt_word;
    logic [WORD_W-1:0] mux_word;

    // Effective code after override resolution.
    always_comb eff_sel = resolve_sel(sel_mode, ovr_loop, ovr_pn);

    // One generator per polynomial, reseeded when one of its codes is entered.
    for (genvar g = 0; g < NGEN; g++) begin : g_gen
        assign restart[g] = (eff_sel != prev_sel) &&
                            (eff_sel == GEN_NORM[g] || eff_sel == GEN_INV[g]);
        dac_prbs_gen #(
            .ORDER (GEN_ORDER[g]),
            .TAP   (GEN_TAP[g]),
            .LANES (LANES),
            .SAMP_W(SAMP_W)
        ) u_gen (
            .clk    (clk),
            .rst_n  (rst_n),
            .restart(restart[g]),
            .word   (pn_word[g])
        );
    end

    // Pattern word: even lanes carry the low value, odd lanes the high value.
    for (genvar l = 0; l < LANES; l++) begin : g_patt
        if (l % 2 == 0) begin : g_even
            assign patt_word[l*SAMP_W +: SAMP_W] = patt_lo;
        end else begin : g_odd
            assign patt_word[l*SAMP_W +: SAMP_W] = patt_hi;
        end
    end

    // Source multiplexer on the effective code.
    always_comb begin
        case (eff_sel)
            SEL_TONE:    mux_word = tone_in;
            SEL_PATTERN: mux_word = patt_word;
            SEL_STREAM:  mux_word = stream_in;
            SEL_NPN7:    mux_word = ~pn_word[0];
            SEL_NPN15:   mux_word = ~pn_word[1];
            SEL_PN7:     mux_word = pn_word[0];
            SEL_PN15:    mux_word = pn_word[1];
            SEL_LOOP:    mux_word = loop_in;
            SEL_PN23:    mux_word = pn_word[2];
            default:     mux_word = '0;
        endcase
    end

    // Output register and previous-code tracker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout     <= '0;
            prev_sel <= SEL_TONE;
        end else begin
            dout     <= mux_word;
            prev_sel <= eff_sel;
        end
    end

    AST_STREAM_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_sel == SEL_STREAM) |=> (dout == $past(stream_in)));  // R9

    AST_ZERO_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_sel == SEL_ZERO || eff_sel > SEL_PN23) |=> (dout == '0));  // R1

    AST_LOOP_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_loop && !ovr_pn) |=> (dout == $past(loop_in)));  // R3

    AST_BOTH_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_loop && ovr_pn && sel_mode == SEL_STREAM) |=> (dout == $past(stream_in)));  // R4

    AST_PATTERN_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_sel == SEL_PATTERN) |=>
            (dout[SAMP_W-1:0] == $past(patt_lo) && dout[2*SAMP_W-1:SAMP_W] == $past(patt_hi)));  // R2
endmodule

// File: rtl/dac_test_src.sv
// Module: top of the test source selector. Replicates the per-channel
// selector and holds the upstream request permanently high.
// Assumes every channel shares one clock and one synchronous reset.
module dac_test_src #(
    parameter int NCH    = 2,
    parameter int SAMP_W = 16,
    parameter int LANES  = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NCH-1:0][3:0]                 sel_mode,
    input  logic [NCH-1:0]                      ovr_loop,
    input  logic [NCH-1:0]                      ovr_pn,
    input  logic [NCH-1:0][SAMP_W-1:0]          patt_lo,
    input  logic [NCH-1:0][SAMP_W-1:0]          patt_hi,
    input  logic [NCH-1:0][LANES*SAMP_W-1:0]    stream_in,
    input  logic [NCH-1:0][LANES*SAMP_W-1:0]    loop_in,
    input  logic [NCH-1:0][LANES*SAMP_W-1:0]    tone_in,
    output logic                                src_valid,
    output logic [NCH-1:0][LANES*SAMP_W-1:0]    dout
);
    // Upstream request is unconditional.
    assign src_valid = 1'b1;

    // One independent selector per channel.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dac_src_chan #(
            .SAMP_W(SAMP_W),
            .LANES (LANES)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_mode (sel_mode[c]),
            .ovr_loop (ovr_loop[c]),
            .ovr_pn   (ovr_pn[c]),
            .patt_lo  (patt_lo[c]),
            .patt_hi  (patt_hi[c]),
            .stream_in(stream_in[c]),
            .loop_in  (loop_in[c]),
            .tone_in  (tone_in[c]),
            .dout     (dout[c])
        );
    end
endmodule

// File: tb/tb_dac_test_src.sv
// Scoreboard bench: drive() applies one cycle of stimulus at the falling
// edge and queues the expected words; the monitor compares after each rise.
module tb_dac_test_src;
    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [1:0][3:0]      sel_mode = '0;
    logic [1:0]           ovr_loop = '0;
    logic [1:0]           ovr_pn = '0;
    logic [1:0][15:0]     patt_lo = '0;
    logic [1:0][15:0]     patt_hi = '0;
    logic [1:0][63:0]     stream_in = '0;
    logic [1:0][63:0]     loop_in = '0;
    logic [1:0][63:0]     tone_in = '0;
    logic                 src_valid;
    logic [1:0][63:0]     dout;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [1:0][63:0] exp;
        string            tag;
    } item_t;
    item_t q[$];

    // Reference generator states per channel: [0]=7-bit, [1]=15-bit, [2]=23-bit.
    logic [22:0] st [2][3];
    logic [3:0]  prev [2];
    localparam int ORD [3] = '{7, 15, 23};
    localparam int TP  [3] = '{6, 14, 18};

    always #4 clk = ~clk;  // 125 MHz

    dac_test_src dut (
        .clk(clk), .rst_n(rst_n), .sel_mode(sel_mode), .ovr_loop(ovr_loop),
        .ovr_pn(ovr_pn), .patt_lo(patt_lo), .patt_hi(patt_hi),
        .stream_in(stream_in), .loop_in(loop_in), .tone_in(tone_in),
        .src_valid(src_valid), .dout(dout)
    );

    function automatic logic [22:0] ones(input int order);
        return (23'd1 << order) - 23'd1;
    endfunction

    // Expand 64 steps of the polynomial into one word, oldest sample first.
    function automatic logic [63:0] pn_word(input int order, input int tap,
                                            inout logic [22:0] s);
        logic [63:0] w;
        logic        fb;
        w = '0;
        for (int i = 0; i < 64; i++) begin
            fb = s[order-1] ^ s[tap-1];
            s  = ((s << 1) | {22'd0, fb}) & ones(order);
            w[(i / 16) * 16 + 15 - (i % 16)] = fb;
        end
        return w;
    endfunction

    task automatic drive(input logic [3:0] s0, input logic [3:0] s1,
                         input logic lb0, input logic pn0,
                         input logic lb1, input logic pn1,
                         input string tag);
        item_t it;
        logic [3:0] sv [2];
        logic       lv [2];
        logic       pv [2];
        sv[0] = s0; sv[1] = s1; lv[0] = lb0; lv[1] = lb1; pv[0] = pn0; pv[1] = pn1;
        for (int c = 0; c < 2; c++) begin
            logic [3:0]  eff;
            logic [63:0] w [3];
            sel_mode[c]  = sv[c];
            ovr_loop[c]  = lv[c];
            ovr_pn[c]    = pv[c];
            stream_in[c] = {$urandom, $urandom};
            loop_in[c]   = {$urandom, $urandom};
            tone_in[c]   = {$urandom, $urandom};
            eff = (lv[c] && !pv[c]) ? 4'h8 : (pv[c] && !lv[c]) ? 4'h9 : sv[c];
            if (!rst_n) begin
                for (int g = 0; g < 3; g++) st[c][g] = ones(ORD[g]);
                prev[c] = 4'h0;
                it.exp[c] = '0;
            end else begin
                if (eff != prev[c]) begin
                    if (eff == 4'h4 || eff == 4'h6) st[c][0] = ones(7);
                    if (eff == 4'h5 || eff == 4'h7) st[c][1] = ones(15);
                    if (eff == 4'h9)                st[c][2] = ones(23);
                end
                for (int g = 0; g < 3; g++) begin
                    logic [22:0] t;
                    t = st[c][g];
                    w[g] = pn_word(ORD[g], TP[g], t);
                    st[c][g] = t;
                end
                case (eff)
                    4'h0: it.exp[c] = tone_in[c];
                    4'h1: it.exp[c] = {patt_hi[c], patt_lo[c], patt_hi[c], patt_lo[c]};
                    4'h2: it.exp[c] = stream_in[c];
                    4'h4: it.exp[c] = ~w[0];
                    4'h5: it.exp[c] = ~w[1];
                    4'h6: it.exp[c] = w[0];
                    4'h7: it.exp[c] = w[1];
                    4'h8: it.exp[c] = loop_in[c];
                    4'h9: it.exp[c] = w[2];
                    default: it.exp[c] = '0;
                endcase
                prev[c] = eff;
            end
        end
        it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Monitor: compare each queued expectation after the edge that produced it.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (src_valid !== 1'b1) begin
                errors++;
                $display("FAIL R10 src_valid got %b exp 1", src_valid);
            end
            for (int c = 0; c < 2; c++) begin
                checks++;
                if (dout[c] !== it.exp[c]) begin
                    errors++;
                    $display("FAIL %s ch%0d got %h exp %h", it.tag, c, dout[c], it.exp[c]);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got running exp finished");
            summary();
            $finish;
        end
    end

    initial begin
        patt_lo[0] = 16'hA55A; patt_hi[0] = 16'h1234;
        patt_lo[1] = 16'h0F0F; patt_hi[1] = 16'hC3C3;
        // R11 R10: outputs zero and valid high while in reset
        drive(4'h2, 4'h0, 0, 0, 0, 0, "R11 reset");
        drive(4'h6, 4'h9, 0, 0, 0, 0, "R11 reset");
        drive(4'h1, 4'h8, 0, 0, 0, 0, "R11 reset");
        rst_n = 1'b1;
        // R1 fixed codes, R9 one-clock latency
        for (int i = 0; i < 3; i++) drive(4'h0, 4'h2, 0, 0, 0, 0, "R1 tone/stream");
        for (int i = 0; i < 2; i++) drive(4'h8, 4'h3, 0, 0, 0, 0, "R1 loop/zero");
        for (int k = 10; k < 16; k++) drive(4'(k), 4'(k), 0, 0, 0, 0, "R1 unused codes");
        for (int i = 0; i < 4; i++) drive(4'h2, 4'h3, 0, 0, 0, 0, "R9 alternate");
        // R2 pattern lanes
        for (int i = 0; i < 2; i++) drive(4'h1, 4'h1, 0, 0, 0, 0, "R2 pattern");
        // R3 single overrides
        for (int i = 0; i < 3; i++) drive(4'h0, 4'h2, 1, 0, 0, 1, "R3 override");
        // R4 both overrides cancel
        for (int i = 0; i < 3; i++) drive(4'h2, 4'h1, 1, 1, 1, 1, "R4 both overrides");
        // R5 7-bit sequence continuity
        for (int i = 0; i < 20; i++) drive(4'h6, 4'h6, 0, 0, 0, 0, "R5 pn7");
        // R7 R8 switch to complemented form reseeds
        for (int i = 0; i < 6; i++) drive(4'h4, 4'h6, 0, 0, 0, 0, "R7 inverted pn7");
        // R6 15-bit and 23-bit sequences
        for (int i = 0; i < 10; i++) drive(4'h7, 4'h9, 0, 0, 0, 0, "R6 pn15/pn23");
        for (int i = 0; i < 5; i++) drive(4'h5, 4'h7, 0, 0, 0, 0, "R7 inverted pn15");
        // R8 reseed on re-entry
        for (int i = 0; i < 3; i++) drive(4'h6, 4'h9, 0, 0, 0, 0, "R8 enter");
        drive(4'h0, 4'h0, 0, 0, 0, 0, "R8 leave");
        for (int i = 0; i < 3; i++) drive(4'h6, 4'h9, 0, 0, 0, 0, "R8 re-enter");
        // R12 channels independent, one on a sequence and one on stream
        for (int i = 0; i < 8; i++) drive(4'h7, 4'h2, 0, 0, 0, 0, "R12 independent");
        // R8 R11 mid-run reset reseeds
        rst_n = 1'b0;
        drive(4'h6, 4'h7, 0, 0, 0, 0, "R11 mid reset");
        drive(4'h6, 4'h7, 0, 0, 0, 0, "R11 mid reset");
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) drive(4'h6, 4'h7, 0, 0, 0, 0, "R8 after reset");
        drive(4'h3, 4'h3, 0, 0, 0, 0, "R1 zero tail");
        while (q.size() != 0) @(posedge clk);
        #3;
        done = 1;
        summary();
        $finish;
    end
endmodule